// File: doc/BRIEF.md
# Round-Robin Transmit Interrupt Scanner

This block decides which of up to 64 serial lines gets the single shared transmit-complete interrupt. Each line carries two flags: an armed flag, set when the host hands the line a character to send, and a request flag, set when an armed line reports that the character has gone out. When something happens that may need an interrupt, a scan starts. The scan walks the lines one per clock, beginning with the line after the one last granted and wrapping to line 0 at the configured line count. It stops at the first line whose request flag is set, moves its pointer there, locks and pulses the interrupt.

While locked, completions from other lines still set their request flags but start no scan. The host reads the locked line number through a read port. The value carries a marker in bit 6, and the read strobe clears that line's request. The lock is released only by the next send or stop command, and that command also starts a fresh scan. A trigger that arrives while a scan is running is held in a one-deep pending latch and is served when the scan ends. Several such triggers merge into one.

The controller has three states: `SC_IDLE` (waiting), `SC_SCAN` (examining one line per clock) and `SC_GRANT` (one cycle in which the lock is set and the interrupt pulses). There are five transitions:
- IDLE to SCAN when a pending trigger is served while unlocked, or while the trigger releases the lock.
- IDLE to IDLE when a pending trigger is dropped because the scanner is locked.
- SCAN to GRANT on a line with its request set.
- SCAN to IDLE after the last line of the sweep has been examined with no hit.
- GRANT to IDLE always.

If a completion sets a line's request flag in the same cycle as a clear of that flag, the set wins.

Top module: `tx_irq_scanner`

## Requirements
- R1: After reset the pointer is 0, so `rd_data` reads 0x40. The scanner is unlocked, `tx_irq` and `busy` are low, and every armed and request flag is clear.
- R2: A command with `cmd_stop`=0 (send) on line L below the line count sets L's armed flag, clears L's request flag, releases the lock and triggers a scan.
- R3: A completion (`done_valid`) on line L below the line count sets L's request flag and triggers a scan without releasing the lock, but only if L is armed. On an unarmed line it has no effect.
- R4: A scan examines lines in the order pointer+1, pointer+2, … and wraps to 0 when the next index reaches the line count, one line per clock, at most line-count lines. On the first line with a request it moves the pointer there, sets the lock and raises `tx_irq` for exactly one cycle. Let the clock edge that samples the trigger strobe be edge 0, and let k be the hit line's position in the order (pointer+1 is position 1). Then `tx_irq` is high in the cycle after edge k+1.
- R5: A scan that finds no request leaves the pointer unchanged, leaves the scanner unlocked and raises no interrupt.
- R6: A trigger that does not release the lock, served while locked, starts no scan, raises no interrupt and leaves the pointer and lock unchanged.
- R7: `rd_data` always equals 0x40 OR the pointer: line number in bits 5:0, bit 6 set, bit 7 clear. A cycle with `rd_strobe` high clears the request flag of the pointed-to line.
- R8: A command with `cmd_stop`=1 on line L below the line count clears L's armed flag, leaves its request flag unchanged, releases the lock and triggers a scan.
- R9: A trigger arriving while a scan runs is latched and served when that scan ends. Any lock release it carries is applied at that point.
- R10: Commands and completions whose line index is not below the line count have no effect. `line_count` of 0 acts as 1, and values above 64 act as 64.
- R11: `busy` is high from the cycle after a trigger is sampled until the scan it starts, or its drop, has completed, and low when no trigger is pending and no scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_count | input | 7 | Number of lines in service, 1 to 64 |
| cmd_valid | input | 1 | Transmit command strobe |
| cmd_stop | input | 1 | Command kind: 0 send character, 1 stop transmit |
| cmd_line | input | 6 | Line addressed by the command |
| done_valid | input | 1 | Character-sent strobe from a line |
| done_line | input | 6 | Line that finished sending |
| rd_strobe | input | 1 | Host read of the granted line; clears its request |
| rd_data | output | 8 | 0x40 OR current pointer |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| locked | output | 1 | Scanner is locked on the pointed line |
| busy | output | 1 | Trigger pending or scan in progress |

## Verification
The assertions check, on every cycle:
- the interrupt pulse lasts a single cycle and is always followed by the lock;
- the granted line lies below the line count;
- the pointer moves only in a grant cycle;
- no interrupt is raised while locked;
- a read strobe clears the pointed line's request.

Only the bench's scenarios can show the rest:
- the order in which lines are searched and the exact grant latency;
- that an unarmed completion or an out-of-range line does nothing;
- that a trigger landing mid-scan is served afterwards.

The bench shows these by running long command sequences against an arithmetic model over several line counts.

// File: rtl/tx_scan_pkg.sv
package tx_scan_pkg;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_GRANT = 2'd2
    } scan_state_t;

    localparam logic [7:0] READ_MARKER = 8'h40;

endpackage

// File: rtl/tx_line_flags.sv
module tx_line_flags #(
    parameter int MAX_LINES = 64,
    parameter int LINE_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_hit,
    input  logic                 cmd_stop,
    input  logic [LINE_W-1:0]    cmd_line,
    input  logic                 done_hit,
    input  logic [LINE_W-1:0]    done_line,
    input  logic                 rd_clr,
    input  logic [LINE_W-1:0]    rd_line,
    output logic [MAX_LINES-1:0] arm_vec,
    output logic [MAX_LINES-1:0] req_vec
);

    for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
        logic arm_q;
        logic req_q;
        logic cmd_here;
        logic set_req;
        logic clr_req;

        always_comb begin
            cmd_here = cmd_hit && (cmd_line == LINE_W'(i));
            set_req  = done_hit && (done_line == LINE_W'(i)) && arm_q;
            clr_req  = (rd_clr && (rd_line == LINE_W'(i))) ||
                       (cmd_here && !cmd_stop);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                arm_q <= 1'b0;
            end else if (cmd_here) begin
                arm_q <= !cmd_stop;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q <= 1'b0;
            end else if (set_req) begin
                req_q <= 1'b1;
            end else if (clr_req) begin
                req_q <= 1'b0;
            end
        end

        assign arm_vec[i] = arm_q;
        assign req_vec[i] = req_q;
    end

endmodule

// File: rtl/tx_trig_latch.sv
module tx_trig_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic trig_unlock,
    input  logic take,
    output logic pend,
    output logic pend_unlock
);

    logic pend_q;
    logic unlock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            unlock_q <= 1'b0;
        end else begin
            pend_q   <= trig || (pend_q && !take);
            unlock_q <= (trig && trig_unlock) || (unlock_q && !take);
        end
    end

    assign pend        = pend_q;
    assign pend_unlock = unlock_q;

endmodule

// File: rtl/tx_scan_ctrl.sv
module tx_scan_ctrl
    import tx_scan_pkg::*;
#(
    parameter int MAX_LINES = 64,
    parameter int LINE_W    = 6,
    parameter int CNT_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pend,
    input  logic                 pend_unlock,
    input  logic [MAX_LINES-1:0] req_vec,
    input  logic [CNT_W-1:0]     count,
    output logic                 take,
    output logic [LINE_W-1:0]    ptr,
    output logic                 locked,
    output logic                 irq,
    output logic                 active
);

    scan_state_t         state_q;
    scan_state_t         state_d;
    logic [LINE_W-1:0]   idx_q;
    logic [CNT_W-1:0]    left_q;
    logic [LINE_W-1:0]   ptr_q;
    logic                locked_q;
    logic                hit;

    function automatic logic [LINE_W-1:0] step_line(
        input logic [LINE_W-1:0] cur,
        input logic [CNT_W-1:0]  cnt
    );
        logic [CNT_W-1:0] nxt;
        nxt = CNT_W'(cur) + CNT_W'(1);
        return (nxt >= cnt) ? '0 : nxt[LINE_W-1:0];
    endfunction

    assign hit = req_vec[idx_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: begin
                if (pend && (!locked_q || pend_unlock)) begin
                    state_d = SC_SCAN;
                end
            end
            SC_SCAN: begin
                if (hit) begin
                    state_d = SC_GRANT;
                end else if (left_q <= CNT_W'(1)) begin
                    state_d = SC_IDLE;
                end
            end
            SC_GRANT: begin
                state_d = SC_IDLE;
            end
            default: begin
                state_d = SC_IDLE;
            end
        endcase
    end

    // scan datapath: cursor, remaining count, pointer, lock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            left_q   <= '0;
            ptr_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            case (state_q)
                SC_IDLE: begin
                    if (pend && pend_unlock) begin
                        locked_q <= 1'b0;
                    end
                    if (pend && (!locked_q || pend_unlock)) begin
                        idx_q  <= step_line(ptr_q, count);
                        left_q <= count;
                    end
                end
                SC_SCAN: begin
                    if (hit) begin
                        ptr_q <= idx_q;
                    end else begin
                        idx_q  <= step_line(idx_q, count);
                        left_q <= left_q - CNT_W'(1);
                    end
                end
                SC_GRANT: begin
                    locked_q <= 1'b1;
                end
                default: begin
                    locked_q <= locked_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        take   = (state_q == SC_IDLE) && pend;
        irq    = (state_q == SC_GRANT);
        active = (state_q != SC_IDLE);
        ptr    = ptr_q;
        locked = locked_q;
    end

endmodule

// File: rtl/tx_irq_scanner.sv
module tx_irq_scanner
    import tx_scan_pkg::*;
#(
    parameter int MAX_LINES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] line_count,
    input  logic       cmd_valid,
    input  logic       cmd_stop,
    input  logic [5:0] cmd_line,
    input  logic       done_valid,
    input  logic [5:0] done_line,
    input  logic       rd_strobe,
    output logic [7:0] rd_data,
    output logic       tx_irq,
    output logic       locked,
    output logic       busy
);

    localparam int LINE_W = 6;
    localparam int CNT_W  = 7;

    logic [CNT_W-1:0]     eff_count;
    logic                 cmd_hit;
    logic                 done_hit;
    logic                 done_trig;
    logic [MAX_LINES-1:0] arm_vec;
    logic [MAX_LINES-1:0] req_vec;
    logic                 pend;
    logic                 pend_unlock;
    logic                 take;
    logic [LINE_W-1:0]    ptr;
    logic                 active;

    always_comb begin
        if (line_count == '0) begin
            eff_count = CNT_W'(1);
        end else if (line_count > CNT_W'(MAX_LINES)) begin
            eff_count = CNT_W'(MAX_LINES);
        end else begin
            eff_count = line_count;
        end
        cmd_hit   = cmd_valid  && (CNT_W'(cmd_line)  < eff_count);
        done_hit  = done_valid && (CNT_W'(done_line) < eff_count);
        done_trig = done_hit && arm_vec[done_line];
    end

    tx_line_flags #(
        .MAX_LINES (MAX_LINES),
        .LINE_W    (LINE_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_hit   (cmd_hit),
        .cmd_stop  (cmd_stop),
        .cmd_line  (cmd_line),
        .done_hit  (done_hit),
        .done_line (done_line),
        .rd_clr    (rd_strobe),
        .rd_line   (ptr),
        .arm_vec   (arm_vec),
        .req_vec   (req_vec)
    );

    tx_trig_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (cmd_hit || done_trig),
        .trig_unlock (cmd_hit),
        .take        (take),
        .pend        (pend),
        .pend_unlock (pend_unlock)
    );

    tx_scan_ctrl #(
        .MAX_LINES (MAX_LINES),
        .LINE_W    (LINE_W),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .pend_unlock (pend_unlock),
        .req_vec     (req_vec),
        .count       (eff_count),
        .take        (take),
        .ptr         (ptr),
        .locked      (locked),
        .irq         (tx_irq),
        .active      (active)
    );

    assign rd_data = READ_MARKER | 8'(ptr);
    assign busy    = active || pend;

endmodule

// File: rtl/tx_irq_scanner_chk.sv
module tx_irq_scanner_chk #(
    parameter int MAX_LINES = 64,
    parameter int LINE_W    = 6,
    parameter int CNT_W     = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_irq,
    input logic                 locked,
    input logic                 rd_strobe,
    input logic                 done_valid,
    input logic [LINE_W-1:0]    done_line,
    input logic [7:0]           rd_data,
    input logic [CNT_W-1:0]     eff_count,
    input logic [MAX_LINES-1:0] req_vec
);

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R4

    AST_IRQ_THEN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> locked); // R4

    AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (CNT_W'(rd_data[LINE_W-1:0]) < eff_count)); // R4

    AST_NO_IRQ_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !tx_irq); // R6

    AST_PTR_MOVES_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> tx_irq); // R5

    AST_READ_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !(done_valid && (done_line == rd_data[LINE_W-1:0])))
        |=> !req_vec[$past(rd_data[LINE_W-1:0])]); // R7

endmodule

bind tx_irq_scanner tx_irq_scanner_chk #(
    .MAX_LINES (MAX_LINES),
    .LINE_W    (LINE_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_irq     (tx_irq),
    .locked     (locked),
    .rd_strobe  (rd_strobe),
    .done_valid (done_valid),
    .done_line  (done_line),
    .rd_data    (rd_data),
    .eff_count  (eff_count),
    .req_vec    (req_vec)
);

// File: tb/tx_irq_scanner_bench.sv
module tx_irq_scanner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] line_count;
    logic       cmd_valid;
    logic       cmd_stop;
    logic [5:0] cmd_line;
    logic       done_valid;
    logic [5:0] done_line;
    logic       rd_strobe;
    logic [7:0] rd_data;
    logic       tx_irq;
    logic       locked;
    logic       busy;

    int n_checks = 0;
    int n_errors = 0;

    bit m_arm [NL];
    bit m_req [NL];
    int m_ptr;
    bit m_lock;
    int m_cnt;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_irq_scanner u_tx_irq_scanner (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_count (line_count),
        .cmd_valid  (cmd_valid),
        .cmd_stop   (cmd_stop),
        .cmd_line   (cmd_line),
        .done_valid (done_valid),
        .done_line  (done_line),
        .rd_strobe  (rd_strobe),
        .rd_data    (rd_data),
        .tx_irq     (tx_irq),
        .locked     (locked),
        .busy       (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_rand(input int range);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:16]) % range;
    endfunction

    // model of one served trigger; returns hit position (0 = none)
    function automatic int mdl_trigger(input bit unlock, output string tag);
        int idx;
        if (unlock) m_lock = 1'b0;
        if (m_lock) begin
            tag = "R6";
            return 0;
        end
        idx = m_ptr;
        for (int i = 1; i <= m_cnt; i++) begin
            idx = (idx + 1 >= m_cnt) ? 0 : idx + 1;
            if (m_req[idx]) begin
                m_ptr  = idx;
                m_lock = 1'b1;
                tag    = "R4";
                return i;
            end
        end
        tag = "R5";
        return 0;
    endfunction

    // runs from a negedge until the block is idle again
    task automatic observe(input int inj_cycle, input int inj_line, input bit trig_expected,
                           output int n_irq, output int first);
        int cyc = 0;
        n_irq = 0;
        first = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            cmd_valid  = 1'b0;
            rd_strobe  = 1'b0;
            done_valid = (cyc == inj_cycle);
            done_line  = 6'(inj_line);
            if (cyc == 1 && trig_expected)
                check(busy == 1'b1, "R11", "busy after trigger", int'(busy), 1);
            if (tx_irq) begin
                n_irq++;
                if (first == 0) first = cyc;
            end
        end while ((busy || cyc < 2 || cyc <= inj_cycle) && cyc < 400);
        check(cyc < 400, "R11", "scan completes", cyc, 0);
        check(busy == 1'b0, "R11", "busy low when idle", int'(busy), 0);
    endtask

    task automatic check_state(input string req);
        check(rd_data == (8'h40 | 8'(m_ptr)), req, "rd_data", int'(rd_data), 'h40 | m_ptr);
        check(locked == m_lock, req, "locked", int'(locked), int'(m_lock));
    endtask

    // kind: 0 send, 1 stop, 2 done, 3 read
    task automatic do_op(input int kind, input int line);
        int    k = 0;
        bit    trig = 1'b0;
        string optag;
        string outtag = "R5";
        int    n_irq;
        int    first;
        bit    in_rng = (line < m_cnt);
        if (kind == 3) begin
            check(rd_data == (8'h40 | 8'(m_ptr)), "R7", "read value", int'(rd_data), 'h40 | m_ptr);
            rd_strobe = 1'b1;
            m_req[m_ptr] = 1'b0;
            observe(0, 0, 1'b0, n_irq, first);
            check(n_irq == 0, "R7", "read raises no irq", n_irq, 0);
            check_state("R7");
            return;
        end
        if (kind == 0) begin
            cmd_valid = 1'b1; cmd_stop = 1'b0; cmd_line = 6'(line);
            optag = in_rng ? "R2" : "R10";
            if (in_rng) begin
                m_arm[line] = 1'b1; m_req[line] = 1'b0; trig = 1'b1;
                k = mdl_trigger(1'b1, outtag);
            end
        end else if (kind == 1) begin
            cmd_valid = 1'b1; cmd_stop = 1'b1; cmd_line = 6'(line);
            optag = in_rng ? "R8" : "R10";
            if (in_rng) begin
                m_arm[line] = 1'b0; trig = 1'b1;
                k = mdl_trigger(1'b1, outtag);
            end
        end else begin
            done_valid = 1'b1; done_line = 6'(line);
            optag = in_rng ? "R3" : "R10";
            if (in_rng && m_arm[line]) begin
                m_req[line] = 1'b1; trig = 1'b1;
                k = mdl_trigger(1'b0, outtag);
            end
        end
        if (!trig) outtag = optag;
        observe(0, 0, trig, n_irq, first);
        check(n_irq == ((k > 0) ? 1 : 0), outtag, "irq count", n_irq, (k > 0) ? 1 : 0);
        if (k > 0)
            check(first == k + 2, "R4", "irq latency cycle", first, k + 2);
        check_state(optag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int n_irq;
        int first;
        int counts [7] = '{1, 2, 3, 5, 8, 64, 0};
        rst_n = 1'b0;
        line_count = 7'd64;
        cmd_valid = 1'b0; cmd_stop = 1'b0; cmd_line = '0;
        done_valid = 1'b0; done_line = '0; rd_strobe = 1'b0;
        for (int i = 0; i < NL; i++) begin m_arm[i] = 1'b0; m_req[i] = 1'b0; end
        m_ptr = 0; m_lock = 1'b0; m_cnt = 64;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rd_data == 8'h40, "R1", "reset rd_data", int'(rd_data), 'h40);
        check(locked == 1'b0, "R1", "reset locked", int'(locked), 0);
        check(tx_irq == 1'b0, "R1", "reset irq", int'(tx_irq), 0);
        check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);

        // R3: completion on an unarmed line is ignored
        do_op(2, 7);
        // R9: arm line 1, then a long empty scan with a completion injected mid-scan
        do_op(0, 1);
        cmd_valid = 1'b1; cmd_stop = 1'b1; cmd_line = 6'd40;
        observe(5, 1, 1'b1, n_irq, first);
        m_arm[40] = 1'b0; m_req[1] = 1'b1; m_ptr = 1; m_lock = 1'b1;
        check(n_irq == 1, "R9", "latched trigger irq count", n_irq, 1);
        check(first == 68, "R9", "latched trigger irq cycle", first, 68);
        check_state("R9");
        // R6: completion while locked does nothing visible
        do_op(0, 9);
        do_op(2, 9);
        do_op(2, 1);

        // near-exhaustive sweeps over line counts
        for (int c = 0; c < 7; c++) begin
            line_count = 7'(counts[c]);
            m_cnt = (counts[c] == 0) ? 1 : counts[c]; // R10: zero acts as one
            for (int n = 0; n < 260; n++) begin
                int kind = next_rand(6);
                int line = next_rand(m_cnt + 2);
                if (line > 63) line = 63;
                if (kind > 3) kind = 2;
                do_op(kind, line);
            end
        end
        // R10: count above the maximum acts as 64
        line_count = 7'd100;
        m_cnt = 64;
        for (int n = 0; n < 60; n++) do_op(next_rand(4), next_rand(64));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule